// File: doc/BRIEF.md
# GPIO Configuration Write Guard

This block holds the per-pin electrical configuration of one GPIO port (pin direction, digital input enable, pull-up select and pull-down select) and protects it from accidental changes. Protection works in two stages. A 32-bit lock register opens the port only when one exact key value is written to it. While the port is open, a per-pin commit register can be changed. The commit bits then decide, pin by pin, which configuration bits accept writes.

Software reaches every register over a simple single-cycle register bus. A write strobe with an address and write data updates the addressed register on the next clock edge. Read data is combinational from the current address. The configuration bits also drive four output vectors that go to the pad logic. By default, pin 0 comes out of reset with its commit bit clear, so its configuration cannot change until software opens the port and commits it. All other pins are writable from reset.

Top module: `gpio_cfg_guard`

## Requirements
- R1: After reset the port is locked. The commit register holds 1 for every pin except the protected pins (default: pin 0), which hold 0. Direction, digital enable, pull-up and pull-down are all 0.
- R2: A write of exactly 0x4C4F434B to the lock register (offset 0x520) opens the port. While the port is open, reading offset 0x520 returns 0x00000000.
- R3: A write of any other value to offset 0x520 locks the port, whether it was open or locked. While the port is locked, reading offset 0x520 returns 0x00000001.
- R4: A write to the commit register (offset 0x524) while the port is locked leaves the commit register unchanged.
- R5: A write to offset 0x524 while the port is open loads the commit register from write data bits [NPINS-1:0]. Bit n belongs to pin n, and 1 means the pin may be reconfigured.
- R6: A write to the direction register (0x100, where 1 means output and 0 means input) or the digital enable register (0x104, where 1 means enabled) changes only the bits whose commit bit is 1. All other bits keep their value.
- R7: A write to the pull-up register (0x108) or the pull-down register (0x10C) updates only committed bits. Each committed pin that the write sets to 1 has its bit in the other pull register cleared in the same cycle. A pin never has both pulls enabled.
- R8: Reading offset 0x524, 0x100, 0x104, 0x108 or 0x10C returns that register zero-extended to 32 bits. Any unmapped offset reads 0.
- R9: The outputs cfg_dir, cfg_den, cfg_pullup and cfg_pulldown always equal the stored direction, digital enable, pull-up and pull-down registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, takes effect on the next rising edge |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| cfg_dir | output | NPINS | Direction per pin (1 = output) |
| cfg_den | output | NPINS | Digital input enable per pin |
| cfg_pullup | output | NPINS | Pull-up select per pin |
| cfg_pulldown | output | NPINS | Pull-down select per pin |

## Verification
A wrong lock state appears as a wrong lock readback value. It shows as soon as the lock offset is read, in the same cycle. It also appears one edge later, when a commit write lands that should have been dropped, or is dropped when it should have landed. A corrupted commit bit appears on the cfg outputs at the first configuration write that touches that pin, one edge after the write strobe. A broken pull interlock shows both pulls high on one pin right after the edge. The reference model is compared against every output and the read data on every cycle, so each of these errors is caught in the cycle it first becomes visible.

// File: rtl/gpio_prot_pkg.sv
package gpio_prot_pkg;
    localparam int unsigned ADDR_W = 12;
    localparam int unsigned DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_DIR    = 12'h100;
    localparam logic [ADDR_W-1:0] OFS_DEN    = 12'h104;
    localparam logic [ADDR_W-1:0] OFS_PUP    = 12'h108;
    localparam logic [ADDR_W-1:0] OFS_PDN    = 12'h10C;
    localparam logic [ADDR_W-1:0] OFS_LOCK   = 12'h520;
    localparam logic [ADDR_W-1:0] OFS_COMMIT = 12'h524;

    localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h4C4F_434B;
    localparam logic [DATA_W-1:0] RD_LOCKED  = 32'h0000_0001;
    localparam logic [DATA_W-1:0] RD_OPEN    = 32'h0000_0000;

    typedef enum logic {
        PORT_LOCKED = 1'b0,
        PORT_OPEN   = 1'b1
    } port_state_e;
endpackage

// File: rtl/gpio_prot_lock.sv
module gpio_prot_lock
    import gpio_prot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              port_open
);
    typedef struct packed {
        port_state_e state;
    } lock_st_t;

    lock_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (lock_wr) begin
            st_d.state = (wdata == UNLOCK_KEY) ? PORT_OPEN : PORT_LOCKED;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: PORT_LOCKED};
        end else begin
            st_q <= st_d;
        end
    end

    assign port_open = (st_q.state == PORT_OPEN);
endmodule

// File: rtl/gpio_prot_commit.sv
module gpio_prot_commit #(
    parameter int unsigned NPINS = 8,
    parameter logic [NPINS-1:0] PROT_MASK = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit_wr,
    input  logic             port_open,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] commit
);
    localparam logic [NPINS-1:0] COMMIT_RST = ~PROT_MASK;

    typedef struct packed {
        logic [NPINS-1:0] bits;
    } commit_st_t;

    commit_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (commit_wr && port_open) begin
            st_d.bits = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{bits: COMMIT_RST};
        end else begin
            st_q <= st_d;
        end
    end

    assign commit = st_q.bits;
endmodule

// File: rtl/gpio_prot_cfg_bank.sv
module gpio_prot_cfg_bank #(
    parameter int unsigned NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_wr,
    input  logic             den_wr,
    input  logic             pup_wr,
    input  logic             pdn_wr,
    input  logic [NPINS-1:0] wdata,
    input  logic [NPINS-1:0] commit,
    output logic [NPINS-1:0] dir,
    output logic [NPINS-1:0] den,
    output logic [NPINS-1:0] pup,
    output logic [NPINS-1:0] pdn
);
    typedef struct packed {
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] den;
        logic [NPINS-1:0] pup;
        logic [NPINS-1:0] pdn;
    } cfg_st_t;

    cfg_st_t st_d, st_q;
    logic [NPINS-1:0] set_bits;

    always_comb begin
        st_d     = st_q;
        set_bits = wdata & commit;
        for (int p = 0; p < int'(NPINS); p++) begin
            if (commit[p]) begin
                if (dir_wr) st_d.dir[p] = wdata[p];
                if (den_wr) st_d.den[p] = wdata[p];
                if (pup_wr) begin
                    st_d.pup[p] = wdata[p];
                    if (set_bits[p]) st_d.pdn[p] = 1'b0;
                end
                if (pdn_wr) begin
                    st_d.pdn[p] = wdata[p];
                    if (set_bits[p]) st_d.pup[p] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dir = st_q.dir;
    assign den = st_q.den;
    assign pup = st_q.pup;
    assign pdn = st_q.pdn;
endmodule

// File: rtl/gpio_cfg_guard.sv
module gpio_cfg_guard
    import gpio_prot_pkg::*;
#(
    parameter int unsigned NPINS = 8,
    parameter logic [NPINS-1:0] PROT_MASK = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NPINS-1:0]  cfg_dir,
    output logic [NPINS-1:0]  cfg_den,
    output logic [NPINS-1:0]  cfg_pullup,
    output logic [NPINS-1:0]  cfg_pulldown
);
    localparam int unsigned PAD_W = DATA_W - NPINS;

    logic             lock_wr, commit_wr, dir_wr, den_wr, pup_wr, pdn_wr;
    logic             port_open;
    logic [NPINS-1:0] commit_q;

    always_comb begin
        lock_wr   = bus_wr && (bus_addr == OFS_LOCK);
        commit_wr = bus_wr && (bus_addr == OFS_COMMIT);
        dir_wr    = bus_wr && (bus_addr == OFS_DIR);
        den_wr    = bus_wr && (bus_addr == OFS_DEN);
        pup_wr    = bus_wr && (bus_addr == OFS_PUP);
        pdn_wr    = bus_wr && (bus_addr == OFS_PDN);
    end

    gpio_prot_lock u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_wr   (lock_wr),
        .wdata     (bus_wdata),
        .port_open (port_open)
    );

    gpio_prot_commit #(
        .NPINS     (NPINS),
        .PROT_MASK (PROT_MASK)
    ) u_commit (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit_wr (commit_wr),
        .port_open (port_open),
        .wdata     (bus_wdata[NPINS-1:0]),
        .commit    (commit_q)
    );

    gpio_prot_cfg_bank #(
        .NPINS (NPINS)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .dir_wr (dir_wr),
        .den_wr (den_wr),
        .pup_wr (pup_wr),
        .pdn_wr (pdn_wr),
        .wdata  (bus_wdata[NPINS-1:0]),
        .commit (commit_q),
        .dir    (cfg_dir),
        .den    (cfg_den),
        .pup    (cfg_pullup),
        .pdn    (cfg_pulldown)
    );

    always_comb begin
        unique case (bus_addr)
            OFS_LOCK:   bus_rdata = port_open ? RD_OPEN : RD_LOCKED;
            OFS_COMMIT: bus_rdata = {{PAD_W{1'b0}}, commit_q};
            OFS_DIR:    bus_rdata = {{PAD_W{1'b0}}, cfg_dir};
            OFS_DEN:    bus_rdata = {{PAD_W{1'b0}}, cfg_den};
            OFS_PUP:    bus_rdata = {{PAD_W{1'b0}}, cfg_pullup};
            OFS_PDN:    bus_rdata = {{PAD_W{1'b0}}, cfg_pulldown};
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_cfg_guard_chk.sv
module gpio_cfg_guard_chk
    import gpio_prot_pkg::*;
#(
    parameter int unsigned NPINS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              port_open,
    input logic [NPINS-1:0]  commit_q,
    input logic [NPINS-1:0]  cfg_dir,
    input logic [NPINS-1:0]  cfg_den,
    input logic [NPINS-1:0]  cfg_pullup,
    input logic [NPINS-1:0]  cfg_pulldown
);
    // R2
    key_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_LOCK && bus_wdata == UNLOCK_KEY) |=> port_open);

    // R3
    other_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_LOCK && bus_wdata != UNLOCK_KEY) |=> !port_open);

    // R4
    commit_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !port_open |=> $stable(commit_q));

    // R6
    dir_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cfg_dir ^ $past(cfg_dir)) & ~$past(commit_q)) == '0);

    // R6
    den_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cfg_den ^ $past(cfg_den)) & ~$past(commit_q)) == '0);

    // R7
    pull_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_pullup & cfg_pulldown) == '0);
endmodule

bind gpio_cfg_guard gpio_cfg_guard_chk #(.NPINS(NPINS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .port_open    (port_open),
    .commit_q     (commit_q),
    .cfg_dir      (cfg_dir),
    .cfg_den      (cfg_den),
    .cfg_pullup   (cfg_pullup),
    .cfg_pulldown (cfg_pulldown)
);

// File: tb/gpio_cfg_guard_tb.sv
module gpio_cfg_guard_tb;
    localparam int NP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [11:0]   bus_addr = 12'h000;
    logic [31:0]   bus_wdata = 32'h0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] cfg_dir, cfg_den, cfg_pullup, cfg_pulldown;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // reference state
    bit            m_open;
    bit [NP-1:0]   m_commit, m_dir, m_den, m_pu, m_pd;

    gpio_cfg_guard u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .cfg_dir      (cfg_dir),
        .cfg_den      (cfg_den),
        .cfg_pullup   (cfg_pullup),
        .cfg_pulldown (cfg_pulldown)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s t=%0t actual=%h expected=%h", req, $time, got, exp);
        end
    endtask

    // model update per edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_open = 0; m_commit = 8'hFE;
            m_dir = 0; m_den = 0; m_pu = 0; m_pd = 0;
        end else if (bus_wr) begin
            case (bus_addr)
                12'h520: m_open = (bus_wdata == 32'h4C4F434B);
                12'h524: if (m_open) m_commit = bus_wdata[NP-1:0];
                12'h100: m_dir = (m_dir & ~m_commit) | (bus_wdata[NP-1:0] & m_commit);
                12'h104: m_den = (m_den & ~m_commit) | (bus_wdata[NP-1:0] & m_commit);
                12'h108: begin
                    m_pu = (m_pu & ~m_commit) | (bus_wdata[NP-1:0] & m_commit);
                    m_pd = m_pd & ~(bus_wdata[NP-1:0] & m_commit);
                end
                12'h10C: begin
                    m_pd = (m_pd & ~m_commit) | (bus_wdata[NP-1:0] & m_commit);
                    m_pu = m_pu & ~(bus_wdata[NP-1:0] & m_commit);
                end
                default: ;
            endcase
        end
    end

    function automatic logic [31:0] exp_rd(input logic [11:0] a);
        case (a)
            12'h520: return m_open ? 32'h0 : 32'h1;
            12'h524: return {24'h0, m_commit};
            12'h100: return {24'h0, m_dir};
            12'h104: return {24'h0, m_den};
            12'h108: return {24'h0, m_pu};
            12'h10C: return {24'h0, m_pd};
            default: return 32'h0;
        endcase
    endfunction

    // compare on every cycle, away from the edge
    always @(negedge clk) begin
        if (cyc > 1) begin
            chk("R9 dir", {24'h0, cfg_dir}, {24'h0, m_dir});
            chk("R6/R9 den", {24'h0, cfg_den}, {24'h0, m_den});
            chk("R7 pullup", {24'h0, cfg_pullup}, {24'h0, m_pu});
            chk("R7 pulldown", {24'h0, cfg_pulldown}, {24'h0, m_pd});
            chk("R8 rdata", bus_rdata, exp_rd(bus_addr));
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #2;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
        @(posedge clk); #2;
        bus_wr = 1'b0; bus_addr = a;
        #3;
        chk(req, bus_rdata, exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1 reset state
        rd("R1 lock", 12'h520, 32'h1);
        rd("R1 commit", 12'h524, 32'hFE);
        rd("R1 dir", 12'h100, 32'h0);
        rd("R1 pullup", 12'h108, 32'h0);
        // R4 commit ignored while locked
        wr(12'h524, 32'hFF);
        rd("R4 commit", 12'h524, 32'hFE);
        // R6 pin 0 frozen
        wr(12'h100, 32'hFF);
        rd("R6 dir", 12'h100, 32'hFE);
        // R3 wrong key keeps locked
        wr(12'h520, 32'h4C4F434A);
        rd("R3 lock", 12'h520, 32'h1);
        // R2 key opens
        wr(12'h520, 32'h4C4F434B);
        rd("R2 lock", 12'h520, 32'h0);
        wr(12'h520, 32'h4C4F434B);
        rd("R2 lock again", 12'h520, 32'h0);
        // R5 commit loads
        wr(12'h524, 32'hFFFF_FF0F);
        rd("R5 commit", 12'h524, 32'h0F);
        wr(12'h524, 32'hFF);
        rd("R5 commit all", 12'h524, 32'hFF);
        wr(12'h100, 32'h01);
        rd("R6 dir open", 12'h100, 32'h01);
        // R3 relock from open
        wr(12'h520, 32'h0);
        rd("R3 relock", 12'h520, 32'h1);
        wr(12'h524, 32'h00);
        rd("R4 commit kept", 12'h524, 32'hFF);
        // R7 pull interlock
        wr(12'h108, 32'h0F);
        wr(12'h10C, 32'h3C);
        rd("R7 pu", 12'h108, 32'h03);
        rd("R7 pd", 12'h10C, 32'h3C);
        wr(12'h108, 32'h30);
        rd("R7 pu2", 12'h108, 32'h30);
        rd("R7 pd2", 12'h10C, 32'h0C);
        // partial commit
        wr(12'h520, 32'h4C4F434B);
        wr(12'h524, 32'h0F);
        wr(12'h520, 32'h12345678);
        wr(12'h104, 32'hFF);
        rd("R6 den", 12'h104, 32'h0F);
        wr(12'h10C, 32'hF3);
        rd("R7 pd3", 12'h10C, 32'h03);
        rd("R7 pu3", 12'h108, 32'h30);
        // R8 unmapped
        rd("R8 unmapped", 12'h000, 32'h0);
        rd("R8 unmapped2", 12'h528, 32'h0);
        repeat (2) @(posedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule